// File: doc/BRIEF.md
# Two-level interrupt aggregator

This block collects 112 level-sensitive interrupt sources into a single summary interrupt line. The sources are split into 14 groups of eight. Each group has a latched pending register, a mask register, a write-one-to-clear register and a real-time level register. Seven groups report to each of two master summary registers. The second master is chained into the first through bit 0 of the master-0 summary, so software starts at one register and walks down only into the groups that are flagged.

Software reaches the registers through a plain synchronous port. The port has a 16-bit address, 8-bit data, and one-cycle read and write strobes. Read data is registered and appears in the cycle after the read strobe. Every register of a group sits at a fixed offset from its master's base. A read and a write to the same address can therefore reach different registers: a pending register for reads and a neighbouring group's clear register for writes.

Top module: `irq_agg_top`

## Requirements
- R1: After reset every pending bit is 0, every mask bit is 1, `irq_o` is 0 and `rd_data_o` is 0x00.
- R2: At each clock edge where a source is high and its mask bit is 0, its pending bit becomes 1. Group b (1 to 7) of master m has its pending register at base(m)+b, where base(0)=0x130 and base(1)=0x1B0.
- R3: Writing to base(m)+b+1 clears the pending bits of group b wherever the write data has a 1, and leaves bits written with 0 unchanged. The clear wins over a set in the same edge, so a source that is still high and unmasked latches again one edge later.
- R4: The mask register of group b is read/write at base(m)+b+8. A mask bit of 1 stops new latching of that source, but it does not remove a bit that is already pending.
- R5: Reading base(m)+b+15 returns the current level of the eight sources of group b, whatever the mask holds.
- R6: Bit b (1 to 7) of the summary register at base(m) is the OR of group b's pending bits. Bit 0 of master 1's summary is always 0.
- R7: Bit 0 of master 0's summary is the OR of all summary bits of master 1.
- R8: Bit i of group b under master m is source `src_i[8*(7*m+b-1)+i]`.
- R9: `irq_o` equals the OR of master 0's summary bits, delayed by one clock.
- R10: A read returns its data in `rd_data_o` on the edge of the read strobe. Addresses with no readable register return 0x00, including base(m)+8, base(m)+0x17 and above, and anything outside both windows.
- R11: Writes to summary, pending-only (base(m)+1) and real-time status addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 112 | Interrupt source levels |
| addr_i | input | 16 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Registered read data |
| irq_o | output | 1 | Summary interrupt |

## Verification
The bench clears a source that is still asserted and reads the group straight away. A design that lets the set win would show the bit as never cleared, and one that drops the relatch would show it staying low. It writes 0 and partial patterns to a clear register, and it masks a bit that is already latched. A design that treats clear as a plain write, or that gates pending with the mask, returns the wrong pending value in those cases. It writes 0xFF to summary, pending-only and real-time addresses, and reads the gaps and the edges of both windows. This exposes a decoder that aliases these addresses onto clear or mask registers. It also raises a source that only master 1 can see, which shows whether the chain bit and the summary line follow.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned BLK_W  = 8;
  localparam logic [ADDR_W-1:0] MST0_BASE  = 16'h0130;
  localparam logic [ADDR_W-1:0] MST_STRIDE = 16'h0080;
  // register offsets relative to base + group number
  localparam int unsigned OFF_CLR  = 1;
  localparam int unsigned OFF_MASK = 8;
  localparam int unsigned OFF_RT   = 15;

  function automatic logic [ADDR_W-1:0] mst_base(input int m);
    return MST0_BASE + MST_STRIDE * ADDR_W'(m);
  endfunction
endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_MST       = 2,
  parameter int unsigned BLK_PER_MST = 7,
  localparam int unsigned SPAN = BLK_PER_MST + OFF_RT + 1,
  localparam int unsigned MW   = (N_MST > 1) ? $clog2(N_MST) : 1,
  localparam int unsigned OW   = $clog2(SPAN)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [MW-1:0]     mst_o,
  output logic [OW-1:0]     off_o
);
  always_comb begin
    hit_o = 1'b0;
    mst_o = '0;
    off_o = '0;
    for (int m = int'(N_MST) - 1; m >= 0; m--) begin
      if ((addr_i >= mst_base(m)) &&
          ((addr_i - mst_base(m)) < ADDR_W'(SPAN))) begin
        hit_o = 1'b1;
        mst_o = MW'(m);
        off_o = OW'(addr_i - mst_base(m));
      end
    end
  end
endmodule

// File: rtl/irq_agg_blk.sv
module irq_agg_blk #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         clr_we_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] pend_q, mask_q, clr_bits;

  assign clr_bits = clr_we_i ? wr_data_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      if (mask_we_i) mask_q <= wr_data_i;
      // clear wins; a still-active source relatches next edge
      pend_q <= (pend_q | (src_i & ~mask_q)) & ~clr_bits;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;

  // R3: cleared bits are low after the clearing edge
  p_clear_drops_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((pend_o & $past(wr_data_i)) == '0));

  // R3: without a clear, latched bits stay
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((pend_o & $past(pend_o)) == $past(pend_o)));

  // R2: an unmasked high source is pending after the edge
  p_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((pend_o & $past(src_i & ~mask_o)) == $past(src_i & ~mask_o)));

  // R4: fully masked and empty stays empty
  p_mask_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o == '0 && mask_o == '1) |=> (pend_o == '0));
endmodule

// File: rtl/irq_agg_sum.sv
module irq_agg_sum #(
  parameter int unsigned N_MST       = 2,
  parameter int unsigned BLK_PER_MST = 7,
  parameter int unsigned BLK_W       = 8,
  parameter int unsigned DATA_W      = 8,
  localparam int unsigned N_BLK = N_MST * BLK_PER_MST
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_BLK-1:0][BLK_W-1:0]    pend_i,
  output logic [N_MST-1:0][DATA_W-1:0]   sum_o,
  output logic                           irq_o
);
  logic [N_BLK-1:0] blk_any;
  logic             irq_q;

  for (genvar g = 0; g < N_BLK; g++) begin : g_any
    assign blk_any[g] = |pend_i[g];
  end

  for (genvar m = 0; m < N_MST; m++) begin : g_mst
    for (genvar b = 1; b <= BLK_PER_MST; b++) begin : g_bit
      assign sum_o[m][b] = blk_any[m*BLK_PER_MST + b - 1];
    end
    for (genvar k = BLK_PER_MST + 1; k < DATA_W; k++) begin : g_pad
      assign sum_o[m][k] = 1'b0;
    end
    if (m == 0 && N_MST > 1) begin : g_chain
      assign sum_o[0][0] = |blk_any[N_BLK-1:BLK_PER_MST];
    end else begin : g_nochain
      assign sum_o[m][0] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |sum_o[0];
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_MST       = 2,
  parameter int unsigned BLK_PER_MST = 7,
  localparam int unsigned N_BLK = N_MST * BLK_PER_MST,
  localparam int unsigned N_SRC = N_BLK * BLK_W,
  localparam int unsigned SPAN  = BLK_PER_MST + OFF_RT + 1,
  localparam int unsigned MW    = (N_MST > 1) ? $clog2(N_MST) : 1,
  localparam int unsigned OW    = $clog2(SPAN),
  localparam int unsigned GW    = (N_BLK > 1) ? $clog2(N_BLK) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic                         dec_hit;
  logic [MW-1:0]                dec_mst;
  logic [OW-1:0]                dec_off;
  logic [N_BLK-1:0]             clr_we, mask_we;
  logic [N_BLK-1:0][BLK_W-1:0]  pend, mask, src_blk;
  logic [N_MST-1:0][DATA_W-1:0] mst_sum;
  logic [DATA_W-1:0]            rd_val, rd_q;
  logic [GW-1:0]                idx;

  assign src_blk = src_i;

  irq_agg_decode #(.N_MST(N_MST), .BLK_PER_MST(BLK_PER_MST)) u_dec (
    .addr_i (addr_i),
    .hit_o  (dec_hit),
    .mst_o  (dec_mst),
    .off_o  (dec_off)
  );

  for (genvar g = 0; g < N_BLK; g++) begin : g_blk
    localparam int unsigned M = g / BLK_PER_MST;
    localparam int unsigned B = g % BLK_PER_MST + 1;
    assign clr_we[g]  = wr_en_i && dec_hit && (dec_mst == MW'(M)) &&
                        (dec_off == OW'(B + OFF_CLR));
    assign mask_we[g] = wr_en_i && dec_hit && (dec_mst == MW'(M)) &&
                        (dec_off == OW'(B + OFF_MASK));
    irq_agg_blk #(.W(BLK_W)) u_blk (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .src_i     (src_blk[g]),
      .clr_we_i  (clr_we[g]),
      .mask_we_i (mask_we[g]),
      .wr_data_i (wr_data_i),
      .pend_o    (pend[g]),
      .mask_o    (mask[g])
    );
  end

  irq_agg_sum #(
    .N_MST(N_MST), .BLK_PER_MST(BLK_PER_MST), .BLK_W(BLK_W), .DATA_W(DATA_W)
  ) u_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .sum_o  (mst_sum),
    .irq_o  (irq_o)
  );

  always_comb begin
    rd_val = '0;
    idx    = '0;
    if (dec_hit) begin
      if (dec_off == '0) begin
        rd_val = mst_sum[dec_mst];
      end else if (dec_off <= OW'(BLK_PER_MST)) begin
        idx    = GW'(int'(dec_mst) * int'(BLK_PER_MST) + int'(dec_off) - 1);
        rd_val = pend[idx];
      end else if (dec_off >= OW'(OFF_MASK + 1) &&
                   dec_off <= OW'(OFF_MASK + BLK_PER_MST)) begin
        idx    = GW'(int'(dec_mst) * int'(BLK_PER_MST) + int'(dec_off) - int'(OFF_MASK) - 1);
        rd_val = mask[idx];
      end else if (dec_off >= OW'(OFF_RT + 1)) begin
        idx    = GW'(int'(dec_mst) * int'(BLK_PER_MST) + int'(dec_off) - int'(OFF_RT) - 1);
        rd_val = src_blk[idx];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_val;
  end

  assign rd_data_o = rd_q;

  // R10: reads outside both windows return zero
  p_unmapped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !dec_hit) |=> (rd_data_o == '0));

  // R9: summary line only follows real pending state
  p_irq_source_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(pend != '0));

  // R7: master-1 activity shows as chain bit in master 0
  p_chain_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend[N_BLK-1:BLK_PER_MST] != '0) |-> mst_sum[0][0]);
endmodule

// File: tb/tb_irq_agg_top.sv
module tb_irq_agg_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [111:0] src = '0;
  logic [15:0]  addr = '0;
  logic         wr_en = 1'b0;
  logic [7:0]   wr_data = '0;
  logic         rd_en = 1'b0;
  logic [7:0]   rd_data;
  logic         irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] msk [14];
  logic [7:0] rv;

  always #10 clk = ~clk;

  irq_agg_top dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  function automatic logic [15:0] base_a(input int m);
    return (m == 0) ? 16'h0130 : 16'h01B0;
  endfunction
  function automatic logic [15:0] a_pend(input int m, input int b); return base_a(m) + 16'(b); endfunction
  function automatic logic [15:0] a_clr (input int m, input int b); return base_a(m) + 16'(b + 1); endfunction
  function automatic logic [15:0] a_mask(input int m, input int b); return base_a(m) + 16'(b + 8); endfunction
  function automatic logic [15:0] a_rt  (input int m, input int b); return base_a(m) + 16'(b + 15); endfunction
  function automatic logic [7:0] src_grp(input int m, input int b);
    return src[8*(7*m + b - 1) +: 8];
  endfunction
  function automatic logic [7:0] exp_pend(input int m, input int b);
    return src_grp(m, b) & ~msk[7*m + b - 1];
  endfunction
  function automatic logic [7:0] exp_sum(input int m);
    logic [7:0] s = '0;
    for (int b = 1; b <= 7; b++) s[b] = |exp_pend(m, b);
    if (m == 0) begin
      for (int b = 1; b <= 7; b++) s[0] = s[0] | (|exp_pend(1, b));
    end
    return s;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int g = 0; g < 14; g++) msk[g] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 rd_data", rd_data, 8'h00);
    rd_chk("R1 mask m0b1", a_mask(0, 1), 8'hFF);
    rd_chk("R1 mask m1b7", a_mask(1, 7), 8'hFF);
    rd_chk("R1 pend m0b4", a_pend(0, 4), 8'h00);
    rd_chk("R1 sum m0", base_a(0), 8'h00);

    // R8 / R2 / R6 / R7 / R9: source only master 1 sees
    wr(a_mask(1, 3), 8'hDF); msk[9] = 8'hDF;
    src[77] = 1'b1;
    src[0]  = 1'b1;                      // masked source in m0 b1
    @(negedge clk); @(negedge clk);
    chk("R9 irq from master1", {7'd0, irq}, 8'h01);
    rd_chk("R2 R8 pend m1b3", a_pend(1, 3), 8'h20);
    rd_chk("R6 sum m1", base_a(1), 8'h08);
    rd_chk("R7 chain bit m0", base_a(0), 8'h01);
    rd_chk("R5 rt m1b3", a_rt(1, 3), 8'h20);
    rd_chk("R5 rt masked m0b1", a_rt(0, 1), 8'h01);
    rd_chk("R4 masked not pending m0b1", a_pend(0, 1), 8'h00);

    // R3 clear while still high: clear wins, then relatch
    wr(a_clr(1, 3), 8'h20);
    rd_chk("R3 cleared", a_pend(1, 3), 8'h00);
    rd_chk("R3 relatched", a_pend(1, 3), 8'h20);

    // R3 zero bits in clear have no effect
    src[77] = 1'b0;
    wr(a_clr(1, 3), 8'h00);
    rd_chk("R3 clear zero", a_pend(1, 3), 8'h20);
    wr(a_clr(1, 3), 8'hDF);
    rd_chk("R3 clear other bits", a_pend(1, 3), 8'h20);
    wr(a_clr(1, 3), 8'h20);
    rd_chk("R3 clear low source", a_pend(1, 3), 8'h00);
    @(negedge clk);
    chk("R9 irq drops", {7'd0, irq}, 8'h00);

    // R4 masking keeps an already latched bit
    src[77] = 1'b1;
    @(negedge clk);
    wr(a_mask(1, 3), 8'hFF); msk[9] = 8'hFF;
    rd_chk("R4 mask readback", a_mask(1, 3), 8'hFF);
    rd_chk("R4 latched survives mask", a_pend(1, 3), 8'h20);
    wr(a_clr(1, 3), 8'h20);
    @(negedge clk);
    rd_chk("R4 no relatch while masked", a_pend(1, 3), 8'h00);
    src[77] = 1'b0;
    src[0]  = 1'b0;

    // R11 writes to read-only addresses
    wr(a_mask(0, 2), 8'hFE); msk[1] = 8'hFE;
    src[8] = 1'b1; @(negedge clk); src[8] = 1'b0;
    @(negedge clk);
    wr(base_a(0), 8'hFF);
    wr(a_pend(0, 1), 8'hFF);
    wr(a_rt(0, 2), 8'hFF);
    wr(a_rt(0, 1), 8'h00);
    wr(a_rt(1, 7), 8'hFF);
    rd_chk("R11 pend kept", a_pend(0, 2), 8'h01);
    rd_chk("R11 sum kept", base_a(0), 8'h04);
    rd_chk("R11 mask m0b1 kept", a_mask(0, 1), 8'hFF);
    rd_chk("R11 mask m0b7 kept", a_mask(0, 7), 8'hFF);

    // R10 unmapped reads, each after a nonzero read
    rd_chk("R10 prime", a_pend(0, 2), 8'h01);
    rd_chk("R10 gap base+8", base_a(0) + 16'h8, 8'h00);
    rd_chk("R10 prime", a_pend(0, 2), 8'h01);
    rd_chk("R10 past window", base_a(0) + 16'h17, 8'h00);
    rd_chk("R10 prime", a_pend(0, 2), 8'h01);
    rd_chk("R10 below window", 16'h012F, 8'h00);
    rd_chk("R10 m1 gap", base_a(1) + 16'h8, 8'h00);
    rd_chk("R10 zero addr", 16'h0000, 8'h00);
    wr(a_clr(0, 2), 8'h01);
    rd_chk("R3 clear via shared addr", a_pend(0, 2), 8'h00);

    // random rounds
    for (int it = 0; it < 20; it++) begin
      logic [127:0] r;
      src = '0;
      for (int g = 0; g < 14; g++) begin
        msk[g] = 8'($urandom);
        wr(a_mask(g / 7, g % 7 + 1), msk[g]);
      end
      for (int g = 0; g < 14; g++) wr(a_clr(g / 7, g % 7 + 1), 8'hFF);
      r = {$urandom, $urandom, $urandom, $urandom};
      if (it % 4 == 0) r[55:0] = '0;   // some rounds: master 1 only
      src = r[111:0];
      @(negedge clk); @(negedge clk);
      chk("R9 irq random", {7'd0, irq}, {7'd0, |exp_sum(0)});
      for (int m = 0; m < 2; m++) begin
        rd_chk("R6 R7 sum random", base_a(m), exp_sum(m));
        for (int b = 1; b <= 7; b++) begin
          rd_chk("R2 R8 pend random", a_pend(m, b), exp_pend(m, b));
          rd_chk("R4 mask random", a_mask(m, b), msk[7*m + b - 1]);
          rd_chk("R5 rt random", a_rt(m, b), src_grp(m, b));
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule